// File: doc/BRIEF.md
# In-Order Issue Hazard Checker

This block controls issue for a pipeline that accepts instructions strictly in program order but lets them finish in any order. Decode is split in two. The first stage is the in-order issue point. It accepts the next decoded instruction only when two conditions hold: the functional unit that instruction needs is free, and no earlier instruction still owes a result to the same destination register. The second stage holds one accepted instruction until both of its source registers have no outstanding writer. It then dispatches the instruction to its unit.

Each functional unit carries a reservation that starts at issue and ends at completion. Each architectural register carries a pending-write flag that is set at issue and cleared at completion. Once dispatched, a unit counts down the latency given with the instruction (1 to 4 cycles) and then raises a one-cycle completion pulse that names the destination register. Because latencies differ, a short operation on one unit can finish before a long operation issued earlier on another unit. Operand values and the execution datapaths are outside this block.

Top module: `issue_ctrl`

## Requirements
- R1: After reset no unit is reserved, no register has a pending write and the holding stage is empty. `iss_ready` is 1 for any in-range unit, and `disp_valid` and every bit of `done_vec` are 0.
- R2: While the unit selected by `iss_unit` is reserved, `iss_ready` is 0. A reservation lasts from the issue cycle until that unit's completion cycle.
- R3: While `iss_dst` has a pending write from an earlier instruction that has not completed, `iss_ready` is 0.
- R4: While the holding stage contains an instruction that does not dispatch in the current cycle, `iss_ready` is 0.
- R5: A held instruction dispatches (`disp_valid` = 1, with `disp_unit` and `disp_dst` equal to its unit and destination) in the first cycle in which neither source A nor source B has a pending write. Either source alone can delay dispatch.
- R6: A source equal to the instruction's own destination does not delay that instruction's dispatch.
- R7: `iss_lat` encodes latency minus one. For an instruction dispatched in cycle c with latency L, `done_vec[u]` is 1 for exactly cycle c+L, where u is its unit. In that cycle the field `done_dst_flat[u*REG_W +: REG_W]` holds its destination. Several units may complete in the same cycle.
- R8: A shorter instruction issued later on a different unit completes before a longer instruction issued earlier.
- R9: A completion in cycle t removes its unit reservation and register pending flag for issue and dispatch decisions in cycle t itself. When an issue sets the same unit or register in that cycle, the set wins over the clear and the new reservation or pending flag remains.
- R10: Instructions dispatch in exactly the order in which they were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Next decoded instruction is present |
| iss_unit | input | FU_W | Functional unit index the instruction needs |
| iss_dst | input | REG_W | Destination register |
| iss_src_a | input | REG_W | First source register |
| iss_src_b | input | REG_W | Second source register |
| iss_lat | input | LAT_W | Execution latency minus one |
| iss_ready | output | 1 | Issue grant; the instruction is accepted when valid and ready are both 1 |
| disp_valid | output | 1 | Held instruction is dispatched this cycle |
| disp_unit | output | FU_W | Unit of the dispatched instruction |
| disp_dst | output | REG_W | Destination of the dispatched instruction |
| done_vec | output | NUM_FU | Per-unit completion pulse |
| done_dst_flat | output | NUM_FU*REG_W | Per-unit destination of the completing instruction |

## Verification
The bench builds the block with its defaults: 16 registers, three units and a 2-bit latency field, so latencies run from 1 to 4. With three units, every unit can be reserved at once, and one stall of each kind (unit, destination, source) can be staged on a separate unit. The 1-versus-4 latency spread makes completion reordering and two units finishing in the same cycle easy to set up. Every stall length the bench expects is a small, exact cycle count.

// File: rtl/issue_pkg.sv
// Shared definitions for the in-order issue hazard checker.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package issue_pkg;

    // Life cycle of one functional unit's reservation.
    typedef enum logic [1:0] {
        SLOT_IDLE     = 2'd0,   // free for a new issue
        SLOT_RESERVED = 2'd1,   // issued, waiting in the holding stage
        SLOT_RUNNING  = 2'd2    // dispatched, counting down latency
    } slot_state_e;

endpackage

// File: rtl/fu_slot.sv
// One functional unit's reservation and latency timer.
// A reservation starts when an instruction issues to this unit. The latency
// count starts when that instruction dispatches. The done pulse lasts one
// cycle, once the stored latency has elapsed.
// Assumes: launch only arrives while RESERVED, and reserve only arrives while
// IDLE or in the done cycle (both guaranteed by the top-level issue logic).
module fu_slot
    import issue_pkg::*;
#(
    parameter int REG_W = 4,
    parameter int LAT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reserve,
    input  logic             launch,
    input  logic [LAT_W-1:0] launch_lat,
    input  logic [REG_W-1:0] launch_dst,
    output logic             busy,
    output logic             done,
    output logic [REG_W-1:0] done_dst
);

    slot_state_e      state_q;
    logic [LAT_W-1:0] cnt_q;
    logic [REG_W-1:0] dst_q;

    // Completion is the last counted cycle of a running operation.
    always_comb begin
        busy     = (state_q != SLOT_IDLE);
        done     = (state_q == SLOT_RUNNING) && (cnt_q == '0);
        done_dst = dst_q;
    end

    // State update: a release from done comes before a same-cycle reservation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            cnt_q   <= '0;
            dst_q   <= '0;
        end else begin
            if (launch) begin
                state_q <= SLOT_RUNNING;
                cnt_q   <= launch_lat;
                dst_q   <= launch_dst;
            end else if (done) begin
                state_q <= reserve ? SLOT_RESERVED : SLOT_IDLE;
            end else if (reserve) begin
                state_q <= SLOT_RESERVED;
            end else if (state_q == SLOT_RUNNING) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pend_table.sv
// Pending-write flags, one per architectural register.
// A flag is set when an instruction writing that register issues. It is
// cleared by a completion pulse that names the register. A set in the same
// cycle as a clear wins, so back-to-back writers keep the flag.
// Assumes each unit's done_dst field is meaningful only while its done bit is 1.
module pend_table #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = 4,
    parameter int NUM_FU   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_en,
    input  logic [REG_W-1:0]         set_idx,
    input  logic [NUM_FU-1:0]        done_vec,
    input  logic [NUM_FU*REG_W-1:0]  done_dst_flat,
    output logic [NUM_REGS-1:0]      pend_q,
    output logic [NUM_REGS-1:0]      clr_vec
);

    // Decode every unit's completion into a per-register clear mask.
    always_comb begin
        clr_vec = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (done_vec[u]) begin
                clr_vec[done_dst_flat[u*REG_W +: REG_W]] = 1'b1;
            end
        end
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        // Per-register flag: issue set has priority over completion clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[r] <= 1'b0;
            end else if (set_en && (set_idx == REG_W'(r))) begin
                pend_q[r] <= 1'b1;
            end else if (clr_vec[r]) begin
                pend_q[r] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ro_stage.sv
// Read-operand holding stage: keeps one issued instruction until neither
// source has an outstanding writer, then dispatches it.
// Assumes pend_eff already has this cycle's completions removed. A source that
// equals the held destination is never waited on: the issue stage refused
// issue while that register was pending, so the only pending writer left is
// the held instruction itself.
module ro_stage #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = 4,
    parameter int FU_W     = 2,
    parameter int LAT_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [FU_W-1:0]     load_unit,
    input  logic [REG_W-1:0]    load_dst,
    input  logic [REG_W-1:0]    load_src_a,
    input  logic [REG_W-1:0]    load_src_b,
    input  logic [LAT_W-1:0]    load_lat,
    input  logic [NUM_REGS-1:0] pend_eff,
    output logic                held,
    output logic                dispatch,
    output logic [FU_W-1:0]     out_unit,
    output logic [REG_W-1:0]    out_dst,
    output logic [LAT_W-1:0]    out_lat
);

    logic             valid_q;
    logic [FU_W-1:0]  unit_q;
    logic [REG_W-1:0] dst_q;
    logic [REG_W-1:0] src_a_q;
    logic [REG_W-1:0] src_b_q;
    logic [LAT_W-1:0] lat_q;
    logic             wait_a;
    logic             wait_b;

    // Source readiness and dispatch decision.
    always_comb begin
        wait_a   = pend_eff[src_a_q] && (src_a_q != dst_q);
        wait_b   = pend_eff[src_b_q] && (src_b_q != dst_q);
        dispatch = valid_q && !wait_a && !wait_b;
        held     = valid_q;
        out_unit = unit_q;
        out_dst  = dst_q;
        out_lat  = lat_q;
    end

    // Holding register: a new load replaces a dispatching entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            unit_q  <= '0;
            dst_q   <= '0;
            src_a_q <= '0;
            src_b_q <= '0;
            lat_q   <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            unit_q  <= load_unit;
            dst_q   <= load_dst;
            src_a_q <= load_src_a;
            src_b_q <= load_src_b;
            lat_q   <= load_lat;
        end else if (dispatch) begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/issue_ctrl.sv
// Top of the in-order issue hazard checker.
// The issue stage grants the next instruction when its unit is free, its
// destination has no pending writer and the holding stage is free or leaving.
// Read-after-write waiting happens in the holding stage, after issue.
// Completions come from per-unit latency timers, so finishing order may
// differ from program order.
// Assumes iss_unit < NUM_FU for useful work; an out-of-range unit never issues.
module issue_ctrl #(
    parameter  int NUM_REGS = 16,
    parameter  int NUM_FU   = 3,
    parameter  int LAT_W    = 2,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int FU_W     = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_valid,
    input  logic [FU_W-1:0]         iss_unit,
    input  logic [REG_W-1:0]        iss_dst,
    input  logic [REG_W-1:0]        iss_src_a,
    input  logic [REG_W-1:0]        iss_src_b,
    input  logic [LAT_W-1:0]        iss_lat,
    output logic                    iss_ready,
    output logic                    disp_valid,
    output logic [FU_W-1:0]         disp_unit,
    output logic [REG_W-1:0]        disp_dst,
    output logic [NUM_FU-1:0]       done_vec,
    output logic [NUM_FU*REG_W-1:0] done_dst_flat
);

    localparam int FU_SLOTS = 1 << FU_W;

    logic [NUM_FU-1:0]   fu_busy;
    logic [NUM_FU-1:0]   fu_done;
    logic [NUM_FU-1:0]   fu_reserve;
    logic [NUM_FU-1:0]   fu_launch;
    logic [FU_SLOTS-1:0] busy_pad;
    logic [NUM_REGS-1:0] pend_q;
    logic [NUM_REGS-1:0] clr_vec;
    logic [NUM_REGS-1:0] pend_eff;
    logic                ro_valid;
    logic                ro_disp;
    logic [FU_W-1:0]     ro_unit;
    logic [REG_W-1:0]    ro_dst;
    logic [LAT_W-1:0]    ro_lat;
    logic                iss_fire;

    // Hazard views with this cycle's completions already released.
    always_comb begin
        pend_eff = pend_q & ~clr_vec;
        busy_pad = '1;
        busy_pad[NUM_FU-1:0] = fu_busy & ~fu_done;
    end

    // Issue grant: free unit, no pending destination, holding stage available.
    always_comb begin
        iss_ready = (!ro_valid || ro_disp) && !busy_pad[iss_unit] && !pend_eff[iss_dst];
        iss_fire  = iss_valid && iss_ready;
    end

    pend_table #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .NUM_FU   (NUM_FU)
    ) u_pend (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_en        (iss_fire),
        .set_idx       (iss_dst),
        .done_vec      (fu_done),
        .done_dst_flat (done_dst_flat),
        .pend_q        (pend_q),
        .clr_vec       (clr_vec)
    );

    ro_stage #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .FU_W     (FU_W),
        .LAT_W    (LAT_W)
    ) u_ro (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (iss_fire),
        .load_unit  (iss_unit),
        .load_dst   (iss_dst),
        .load_src_a (iss_src_a),
        .load_src_b (iss_src_b),
        .load_lat   (iss_lat),
        .pend_eff   (pend_eff),
        .held       (ro_valid),
        .dispatch   (ro_disp),
        .out_unit   (ro_unit),
        .out_dst    (ro_dst),
        .out_lat    (ro_lat)
    );

    for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
        // Steer issue and dispatch strobes to this unit.
        always_comb begin
            fu_reserve[u] = iss_fire && (iss_unit == FU_W'(u));
            fu_launch[u]  = ro_disp && (ro_unit == FU_W'(u));
        end

        fu_slot #(
            .REG_W (REG_W),
            .LAT_W (LAT_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .reserve    (fu_reserve[u]),
            .launch     (fu_launch[u]),
            .launch_lat (ro_lat),
            .launch_dst (ro_dst),
            .busy       (fu_busy[u]),
            .done       (fu_done[u]),
            .done_dst   (done_dst_flat[u*REG_W +: REG_W])
        );
    end

    // Drive the dispatch and completion ports.
    always_comb begin
        disp_valid = ro_disp;
        disp_unit  = ro_unit;
        disp_dst   = ro_dst;
        done_vec   = fu_done;
    end

endmodule

// File: rtl/issue_ctrl_chk.sv
// Assertion checker for issue_ctrl, attached with bind.
// Relates the issue grant, the holding stage, the unit reservations and the
// pending flags across cycles.
module issue_ctrl_chk #(
    parameter int NUM_REGS = 16,
    parameter int NUM_FU   = 3,
    parameter int REG_W    = 4,
    parameter int FU_W     = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                iss_valid,
    input logic                iss_ready,
    input logic [FU_W-1:0]     iss_unit,
    input logic [REG_W-1:0]    iss_dst,
    input logic                disp_valid,
    input logic [NUM_FU-1:0]   done_vec,
    input logic                ro_valid,
    input logic [NUM_FU-1:0]   fu_busy,
    input logic [NUM_REGS-1:0] pend_q,
    input logic [NUM_REGS-1:0] clr_vec
);

    // An accepted instruction leaves its unit reserved in the next cycle.
    assert_unit_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> fu_busy[$past(iss_unit)]);

    // No grant to a destination with a writer that is not completing.
    assert_no_waw_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |-> (!pend_q[iss_dst] || clr_vec[iss_dst]));

    // A held instruction that stays blocks the issue stage.
    assert_hold_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_valid && !disp_valid) |-> !iss_ready);

    // Dispatch only comes from an occupied holding stage.
    assert_disp_from_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ro_valid);

    // The destination set at issue is pending in the next cycle, even on a same-cycle clear.
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> pend_q[$past(iss_dst)]);

    for (genvar u = 0; u < NUM_FU; u++) begin : g_done
        // A completion pulse on one unit never lasts two cycles.
        assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
            done_vec[u] |=> !done_vec[u]);
    end

endmodule

bind issue_ctrl issue_ctrl_chk #(
    .NUM_REGS (NUM_REGS),
    .NUM_FU   (NUM_FU),
    .REG_W    (REG_W),
    .FU_W     (FU_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .iss_unit   (iss_unit),
    .iss_dst    (iss_dst),
    .disp_valid (disp_valid),
    .done_vec   (done_vec),
    .ro_valid   (ro_valid),
    .fu_busy    (fu_busy),
    .pend_q     (pend_q),
    .clr_vec    (clr_vec)
);

// File: tb/sim_issue_ctrl.sv
// Scoreboard bench for issue_ctrl. The driver pushes each accepted instruction
// into an expectation queue. The monitor pops it on dispatch, checks order and
// fields, then predicts the completion cycle from the latency.
module sim_issue_ctrl;

    localparam int NREG  = 16;
    localparam int NFU   = 3;
    localparam int LATW  = 2;
    localparam int RW    = 4;
    localparam int FW    = 2;

    typedef struct {
        int unit;
        int dst;
        int lat;
    } item_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           iss_valid = 1'b0;
    logic [FW-1:0]  iss_unit = '0;
    logic [RW-1:0]  iss_dst = '0;
    logic [RW-1:0]  iss_src_a = '0;
    logic [RW-1:0]  iss_src_b = '0;
    logic [LATW-1:0] iss_lat = '0;
    logic           iss_ready;
    logic           disp_valid;
    logic [FW-1:0]  disp_unit;
    logic [RW-1:0]  disp_dst;
    logic [NFU-1:0] done_vec;
    logic [NFU*RW-1:0] done_dst_flat;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    item_t expq[$];
    int    due[NFU];
    bit    due_on[NFU];
    int    due_dst[NFU];
    int    disp_cyc[NREG];
    int    done_cyc[NREG];

    issue_ctrl #(.NUM_REGS(NREG), .NUM_FU(NFU), .LAT_W(LATW)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .iss_valid     (iss_valid),
        .iss_unit      (iss_unit),
        .iss_dst       (iss_dst),
        .iss_src_a     (iss_src_a),
        .iss_src_b     (iss_src_b),
        .iss_lat       (iss_lat),
        .iss_ready     (iss_ready),
        .disp_valid    (disp_valid),
        .disp_unit     (disp_unit),
        .disp_dst      (disp_dst),
        .done_vec      (done_vec),
        .done_dst_flat (done_dst_flat)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Drive one instruction at posedge+1 until accepted; report stall count and accept cycle.
    task automatic send(input int unit, input int dst, input int sa, input int sb,
                        input int lat, output int waits, output int acc);
        iss_valid = 1'b1;
        iss_unit  = FW'(unit);
        iss_dst   = RW'(dst);
        iss_src_a = RW'(sa);
        iss_src_b = RW'(sb);
        iss_lat   = LATW'(lat - 1);
        waits = 0;
        @(negedge clk);
        while (!iss_ready) begin
            waits++;
            @(negedge clk);
        end
        acc = cyc;
        expq.push_back('{unit, dst, lat});
        @(posedge clk);
        #1;
        iss_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor: completion timing (R7) then dispatch order and fields (R10).
    always @(negedge clk) begin
        if (rst_n) begin
            for (int u = 0; u < NFU; u++) begin
                bit exp_d;
                exp_d = due_on[u] && (due[u] == cyc);
                if (exp_d || done_vec[u]) begin
                    check(done_vec[u] == exp_d, "R7", $sformatf("done pulse unit %0d", u),
                          int'(done_vec[u]), int'(exp_d));
                    if (exp_d && done_vec[u]) begin
                        check(int'(done_dst_flat[u*RW +: RW]) == due_dst[u], "R7", "done dst",
                              int'(done_dst_flat[u*RW +: RW]), due_dst[u]);
                        done_cyc[due_dst[u]] = cyc;
                    end
                end
                if (exp_d) due_on[u] = 1'b0;
            end
            if (disp_valid) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R10", "dispatch with nothing issued", int'(disp_dst), -1);
                end else begin
                    item_t it;
                    it = expq.pop_front();
                    check(int'(disp_unit) == it.unit, "R10", "dispatch unit", int'(disp_unit), it.unit);
                    check(int'(disp_dst) == it.dst, "R10", "dispatch dst", int'(disp_dst), it.dst);
                    disp_cyc[it.dst] = cyc;
                    due[it.unit]     = cyc + it.lat;
                    due_dst[it.unit] = it.dst;
                    due_on[it.unit]  = 1'b1;
                end
            end
        end
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        finish_run();
    end

    initial begin
        int w, a, w2, a2;
        for (int i = 0; i < NREG; i++) begin
            disp_cyc[i] = -1;
            done_cyc[i] = -1;
        end
        for (int u = 0; u < NFU; u++) due_on[u] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(iss_ready == 1'b1, "R1", "ready after reset", int'(iss_ready), 1);
        check(disp_valid == 1'b0, "R1", "no dispatch after reset", int'(disp_valid), 0);
        check(done_vec == '0, "R1", "no completion after reset", int'(done_vec), 0);
        @(posedge clk);
        #1;

        // R2 + R9: second op on a busy unit waits for the done cycle (latency 4).
        send(0, 1, 0, 0, 4, w, a);
        check(w == 0, "R2", "first issue stalls", w, 0);
        send(0, 2, 0, 0, 1, w, a);
        check(w == 4, "R2", "same-unit stall length (issue in done cycle, R9)", w, 4);
        idle(8);

        // R3 + R9: destination conflict, then the re-written register stays pending.
        send(0, 3, 0, 0, 3, w, a);
        send(1, 3, 0, 0, 3, w, a);
        check(w == 3, "R3", "same-destination stall length", w, 3);
        send(2, 5, 3, 0, 1, w, a);
        check(w == 0, "R3", "reader of pending dst issues freely", w, 0);
        idle(8);
        check(disp_cyc[5] == a + 3, "R9", "reader waits for second writer", disp_cyc[5] - a, 3);

        // R5 + R4 + R9: source B waits in holding stage; next issue is blocked.
        send(0, 6, 0, 0, 4, w, a);
        send(1, 7, 0, 6, 1, w, a);
        check(w == 0, "R5", "reader issues while writer runs", w, 0);
        send(2, 8, 0, 0, 1, w2, a2);
        check(w2 == 3, "R4", "issue blocked by waiting holding stage", w2, 3);
        idle(8);
        check(disp_cyc[7] == a + 4, "R5", "dispatch in writer's done cycle", disp_cyc[7] - a, 4);
        check(disp_cyc[8] == a2 + 1, "R4", "follower dispatches next cycle", disp_cyc[8] - a2, 1);

        // R6: source equal to own destination.
        send(0, 9, 9, 9, 2, w, a);
        idle(6);
        check(disp_cyc[9] == a + 1, "R6", "self-source dispatch delay", disp_cyc[9] - a, 1);

        // R8: long op first, short op later on another unit.
        send(0, 10, 0, 0, 4, w, a);
        send(1, 11, 0, 0, 1, w, a);
        idle(8);
        check(done_cyc[11] < done_cyc[10], "R8", "short op finishes first", done_cyc[11], done_cyc[10]);
        check(done_cyc[10] == disp_cyc[10] + 4, "R7", "latency 4 completion", done_cyc[10] - disp_cyc[10], 4);

        // R7: two units completing in the same cycle.
        send(0, 12, 0, 0, 2, w, a);
        send(1, 13, 0, 0, 1, w, a);
        idle(8);
        check(done_cyc[12] == done_cyc[13], "R7", "simultaneous completions", done_cyc[12], done_cyc[13]);
        check(done_cyc[12] > 0, "R7", "completion seen", done_cyc[12], 1);

        // R10: everything issued was dispatched.
        check(expq.size() == 0, "R10", "scoreboard drained", expq.size(), 0);
        finish_run();
    end

endmodule